// File: doc/BRIEF.md
# Staged Display Enable Sequencer

This block brings the four stages of a display output path up and down in a safe order. The stages are the pixel clock, the sync timing generator, the display signal and the backlight PWM. Software asks for a stage to turn on or off by writing a one to its bit in a set word or in a clear word. The block records each request and acts on it only when the stages it depends on are in the required state. It then drives the stage's enable line and reports the stage as settled on a status output after a programmable delay.

Only one stage changes at a time. A pending switch-off is always served before a pending switch-on. Among several switch-offs the order is display, sync, clock, PWM. Among several switch-ons the order is clock, sync, display, PWM. Software waits for each status bit to reach its final value, and it always gets there, because the settle delay is a plain counter.

Top module: `stage_power_seq`

## Requirements
- R1: While reset is asserted, and right after it, every bit of `stage_on` and `status` is 0 and no earlier request is still pending.
- R2: The stage bit positions are: bit 0 pixel clock, bit 1 sync, bit 2 display, bit 3 PWM. A 1 in `en_set` asks for that stage to turn on. A 1 in `dis_set` asks for it to turn off. A 0 bit changes nothing. A request stays pending until it has been served.
- R3: When the same bit is 1 in both `en_set` and `dis_set` in one cycle, the turn-off request wins.
- R4: At most one stage has `stage_on` different from `status` at any time. When the block is idle, `stage_on` changes on the clock edge after the edge that captured the request. `status[s]` takes the value of `stage_on[s]` exactly N edges after `stage_on[s]` changed.
- R5: N equals `settle_len` when it is nonzero. When `settle_len` is 0, N is 4. The value is sampled at the edge where the stage's transition starts.
- R6: If all four stages are requested on together, they turn on in the order clock, sync, display, PWM, each one starting after the previous one has settled.
- R7: If all four stages are requested off together, they turn off in the order display, sync, clock, PWM.
- R8: Sync cannot turn on while clock status is 0, and display cannot turn on while sync status is 0. Such a request is held and served once the condition is met.
- R9: Clock cannot turn off while sync status is 1, and sync cannot turn off while display status is 1. Such a request is deferred until the condition is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set | input | 4 | Write-one-to-request-on strobes, one per stage |
| dis_set | input | 4 | Write-one-to-request-off strobes, one per stage |
| settle_len | input | 8 | Settle delay in cycles; 0 selects 4 |
| stage_on | output | 4 | Enable line driven to each stage |
| status | output | 4 | Settled state of each stage |

## Verification
The assertions assume that `settle_len` holds still while a stage is settling and that the strobes are driven only between clock edges. The stimulus meets both: it changes `settle_len` only after every stage has settled, and it applies each strobe word for exactly one cycle, starting at a falling edge. The ordering checks use a fixed settle length, so the exact edge of every transition in a power-up or power-down run can be worked out ahead of time.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int NSTAGE     = 4;
    localparam int IDXW       = $clog2(NSTAGE);
    // Stages 0..CHAIN_LAST form a chain: each needs the one below it active.
    localparam int CHAIN_LAST = 2;

    typedef logic [IDXW-1:0]   idx_t;
    typedef logic [NSTAGE-1:0] vec_t;

    // Service priority for turn-off and turn-on actions (first entry wins).
    localparam idx_t OFF_ORDER [NSTAGE] = '{idx_t'(2), idx_t'(1), idx_t'(0), idx_t'(3)};
    localparam idx_t ON_ORDER  [NSTAGE] = '{idx_t'(0), idx_t'(1), idx_t'(2), idx_t'(3)};

    function automatic logic dep_on_ok(input int s, input vec_t st);
        if (s >= 1 && s <= CHAIN_LAST) return st[s-1];
        return 1'b1;
    endfunction

    function automatic logic dep_off_ok(input int s, input vec_t st);
        if (s < CHAIN_LAST) return !st[s+1];
        return 1'b1;
    endfunction
endpackage

// File: rtl/sps_request.sv
module sps_request
    import sps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  vec_t en_set,
    input  vec_t dis_set,
    output vec_t tgt
);
    typedef struct packed {
        vec_t tgt;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d     = req_q;
        req_d.tgt = (req_q.tgt | en_set) & ~dis_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign tgt = req_q.tgt;

    AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(en_set & dis_set)) |=> ((tgt & $past(en_set & dis_set)) == '0)); // R3
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set == '0 && dis_set == '0) |=> $stable(tgt)); // R2
endmodule

// File: rtl/sps_arbiter.sv
module sps_arbiter
    import sps_pkg::*;
(
    input  logic idle,
    input  vec_t tgt,
    input  vec_t status,
    output logic go,
    output idx_t go_idx,
    output logic go_on
);
    logic found;

    always_comb begin
        found  = 1'b0;
        go_idx = '0;
        go_on  = 1'b0;
        for (int p = 0; p < NSTAGE; p++) begin
            if (!found && !tgt[OFF_ORDER[p]] && status[OFF_ORDER[p]]
                && dep_off_ok(int'(OFF_ORDER[p]), status)) begin
                found  = 1'b1;
                go_idx = OFF_ORDER[p];
                go_on  = 1'b0;
            end
        end
        for (int p = 0; p < NSTAGE; p++) begin
            if (!found && tgt[ON_ORDER[p]] && !status[ON_ORDER[p]]
                && dep_on_ok(int'(ON_ORDER[p]), status)) begin
                found  = 1'b1;
                go_idx = ON_ORDER[p];
                go_on  = 1'b1;
            end
        end
        go = found && idle;
    end
endmodule

// File: rtl/sps_settle.sv
module sps_settle #(
    parameter int CW        = 8,
    parameter int SETTLE_DEF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          busy,
    output logic          done
);
    localparam logic [CW-1:0] DEF_LEN = CW'(SETTLE_DEF);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CW-1:0] eff_len;

    always_comb begin
        eff_len = (len == '0) ? DEF_LEN : len;
        tmr_d   = tmr_q;
        if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = eff_len - CW'(1);
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
    assign done = tmr_q.busy && (tmr_q.cnt == '0);

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R4
endmodule

// File: rtl/stage_power_seq.sv
module stage_power_seq #(
    parameter int CW         = 8,
    parameter int SETTLE_DEF = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [sps_pkg::NSTAGE-1:0] en_set,
    input  logic [sps_pkg::NSTAGE-1:0] dis_set,
    input  logic [CW-1:0]              settle_len,
    output logic [sps_pkg::NSTAGE-1:0] stage_on,
    output logic [sps_pkg::NSTAGE-1:0] status
);
    import sps_pkg::*;

    typedef struct packed {
        vec_t on;
        vec_t st;
        idx_t idx;
    } seq_t;

    seq_t seq_d, seq_q;
    vec_t tgt;
    logic go, go_on, busy, done;
    idx_t go_idx;

    sps_request u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_set (en_set),
        .dis_set(dis_set),
        .tgt    (tgt)
    );

    sps_arbiter u_arb (
        .idle  (!busy),
        .tgt   (tgt),
        .status(seq_q.st),
        .go    (go),
        .go_idx(go_idx),
        .go_on (go_on)
    );

    sps_settle #(.CW(CW), .SETTLE_DEF(SETTLE_DEF)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(go),
        .len  (settle_len),
        .busy (busy),
        .done (done)
    );

    always_comb begin
        seq_d = seq_q;
        if (go) begin
            seq_d.on[go_idx] = go_on;
            seq_d.idx        = go_idx;
        end
        if (done) seq_d.st[seq_q.idx] = seq_q.on[seq_q.idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign stage_on = seq_q.on;
    assign status   = seq_q.st;

    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stage_on ^ status) <= 1); // R4
    AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (status != $past(status)) |-> (status == stage_on)); // R4
    AST_SYNC_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        stage_on[1] |-> status[0]); // R8
    AST_DISP_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        stage_on[2] |-> status[1]); // R8
    AST_CLK_OFF_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stage_on[0]) |-> !status[1]); // R9
endmodule

// File: tb/tb_stage_power_seq.sv
module tb_stage_power_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] en_set = '0;
    logic [3:0] dis_set = '0;
    logic [7:0] settle_len = 8'd4;
    logic [3:0] stage_on, status;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stage_power_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set    (en_set),
        .dis_set   (dis_set),
        .settle_len(settle_len),
        .stage_on  (stage_on),
        .status    (status)
    );

    // {en, dis, settle, expected stage_on, expected status}, each after 40 cycles
    localparam logic [23:0] VEC [NV] = '{
        {4'b0001, 4'b0000, 8'd4, 4'b0001, 4'b0001},  // R2 clock on
        {4'b0100, 4'b0000, 8'd4, 4'b0001, 4'b0001},  // R8 display held
        {4'b0010, 4'b0000, 8'd4, 4'b0111, 4'b0111},  // R8 sync then display
        {4'b1000, 4'b0000, 8'd4, 4'b1111, 4'b1111},  // R2 pwm on
        {4'b0000, 4'b0001, 8'd4, 4'b1111, 4'b1111},  // R9 clock off deferred
        {4'b0000, 4'b0110, 8'd4, 4'b1000, 4'b1000},  // R9 deferred clock off served
        {4'b0000, 4'b0000, 8'd4, 4'b1000, 4'b1000},  // R2 zero write
        {4'b1000, 4'b1000, 8'd4, 4'b0000, 4'b0000},  // R3 disable wins
        {4'b0001, 4'b0000, 8'd1, 4'b0001, 4'b0001},  // R5 settle 1
        {4'b1111, 4'b0001, 8'd4, 4'b1000, 4'b1000},  // R3 mixed word
        {4'b0001, 4'b0000, 8'd0, 4'b1111, 4'b1111},  // R8 pending ons served
        {4'b0000, 4'b1111, 8'd4, 4'b0000, 4'b0000}   // R7 all off
    };

    task automatic check(input logic [3:0] exp_on, input logic [3:0] exp_st, input string req);
        checks++;
        if (stage_on !== exp_on || status !== exp_st) begin
            errors++;
            $display("FAIL %s: stage_on=%b status=%b expected stage_on=%b status=%b",
                     req, stage_on, status, exp_on, exp_st);
        end
    endtask

    task automatic strobe(input logic [3:0] en, input logic [3:0] dis);
        @(negedge clk);
        en_set  = en;
        dis_set = dis;
        @(negedge clk);
        en_set  = '0;
        dis_set = '0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        check(4'b0000, 4'b0000, "R1 in reset");
        rst_n = 1'b1;
        wait_cyc(1);
        check(4'b0000, 4'b0000, "R1 after reset");

        // Power-up timing and order, N = 4
        strobe(4'b1111, 4'b0000);
        wait_cyc(1);  check(4'b0001, 4'b0000, "R4 clock starts next edge");
        wait_cyc(3);  check(4'b0001, 4'b0000, "R4 status not before N");
        wait_cyc(1);  check(4'b0001, 4'b0001, "R4 status at N");
        wait_cyc(1);  check(4'b0011, 4'b0001, "R6 sync after clock");
        wait_cyc(40); check(4'b1111, 4'b1111, "R6 all on");

        // Power-down order
        strobe(4'b0000, 4'b1111);
        wait_cyc(1);  check(4'b1011, 4'b1111, "R7 display first");
        wait_cyc(5);  check(4'b1001, 4'b1011, "R7 sync second");
        wait_cyc(5);  check(4'b1000, 4'b1001, "R7 clock third");
        wait_cyc(5);  check(4'b0000, 4'b1000, "R7 pwm last");
        wait_cyc(10); check(4'b0000, 4'b0000, "R7 all off");

        // Default settle length
        settle_len = 8'd0;
        strobe(4'b0001, 4'b0000);
        wait_cyc(4);  check(4'b0001, 4'b0000, "R5 default not before 4");
        wait_cyc(1);  check(4'b0001, 4'b0001, "R5 default at 4");
        strobe(4'b0000, 4'b0001);
        wait_cyc(10);

        // Longer settle length
        settle_len = 8'd7;
        strobe(4'b0001, 4'b0000);
        wait_cyc(7);  check(4'b0001, 4'b0000, "R5 not before 7");
        wait_cyc(1);  check(4'b0001, 4'b0001, "R5 at 7");

        // Reset in the middle of a sequence
        settle_len = 8'd4;
        strobe(4'b1110, 4'b0000);
        wait_cyc(2);
        rst_n = 1'b0;
        wait_cyc(1);
        check(4'b0000, 4'b0000, "R1 reset mid-sequence");
        rst_n = 1'b1;
        wait_cyc(40);
        check(4'b0000, 4'b0000, "R1 no pending request after reset");

        for (int i = 0; i < NV; i++) begin
            settle_len = VEC[i][15:8];
            strobe(VEC[i][23:20], VEC[i][19:16]);
            wait_cyc(40);
            check(VEC[i][7:4], VEC[i][3:0], $sformatf("vector %0d (R2 R3 R5 R7 R8 R9)", i));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule